// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This controller chooses the power state of a system board's dual rails from two active-low sleep requests. A high level on both requests selects the active state S0. A low S3 request with a high S5 request selects the S3 sleep state. A low S5 request selects S4/S5. The controller drives four digital enables: a gate-pull that holds the main-supply pass switches off, an on command for the standby P-switch that feeds the 5V dual rail, a soft ramp current for that P-switch, and an enable for the internal 3.3V standby regulator. A level code reports the state the outputs represent.

Both request pins pass through a synchronizer before they are decoded. The controller ignores any attempt to go from S4/S5 straight to S3. S0 to S3 takes effect only after a qualification delay, while S0 to S4/S5 takes effect at once. Wake to S0 waits until the 12V rail has stayed good for a set number of soft-start intervals, and then every rail switches over in one clock edge. The standby power-on-reset qualifier gates the whole sequence. After that qualifier rises, the board runs one soft-start interval on the internal regulator before it settles into a sleep state. A parameter selects whether the 5V dual rail stays on in S4/S5.

Top module: `sleep_rail_sequencer`

## Requirements
- R1: The request pins are decoded after a SYNC_STAGES-flop synchronizer. slp5_n low means S4/S5 whatever slp3_n is. slp3_n low with slp5_n high means S3. Both high means S0. With SYNC_STAGES=2, a pin change first affects the outputs on the third rising edge after it.
- R2: While rst is high, or while sby_por_ok is low, the outputs read main_gate_pull=1, psw_on=0, psw_ramp=0, ldo_en=0 and pwr_level=2'b11. These outputs appear one edge after sby_por_ok falls.
- R3: One edge after sby_por_ok rises, the boot interval begins with ldo_en=1, psw_on=0 and pwr_level=2'b11. During boot, psw_ramp is 1 only when the requested sleep state powers the 5V dual rail. On the first ss_tick of boot the controller enters S3 if S3 is requested and S4/S5 otherwise.
- R4: In S3 the outputs read main_gate_pull=1, psw_on=1, psw_ramp=0, ldo_en=1 and pwr_level=2'b01.
- R5: In S4/S5 the outputs read main_gate_pull=1, psw_on=KEEP_5V_IN_S45, psw_ramp=0, ldo_en=1 and pwr_level=2'b10.
- R6: An S3 request made while in S4/S5 is ignored, and the outputs stay at their S4/S5 values.
- R7: From S0, an S4/S5 request switches the outputs to S4/S5 after the synchronizer latency alone.
- R8: From S0, an S3 request takes effect on the ENTRY_DELAY_CYCLES-th consecutive edge on which it is seen. Any other request seen in between restarts the count.
- R9: A wake request leaves the sleep outputs unchanged until WAKE_TICKS ss_tick pulses have been seen while rail12_good stays high. A low rail12_good clears the count.
- R10: When wake completes, main_gate_pull, psw_on and ldo_en all fall in the same edge and pwr_level becomes 2'b00.
- R11: If the request leaves S0 during a wake, the controller goes back to its sleep state: S4/S5 if S4/S5 is requested, otherwise the state it woke from. The wake count starts again on the next wake.
- R12: main_gate_pull=0 and psw_on=1 are never present at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sby_por_ok | input | 1 | Standby supply past its power-on-reset level |
| slp3_n | input | 1 | Active-low S3 request, asynchronous |
| slp5_n | input | 1 | Active-low S4/S5 request, asynchronous |
| rail12_good | input | 1 | 12V rail above its power-on-reset level |
| ss_tick | input | 1 | One-cycle pulse marking each soft-start interval |
| main_gate_pull | output | 1 | 1 holds the main pass-switch gates low (switches off) |
| psw_on | output | 1 | Standby P-switch fully on |
| psw_ramp | output | 1 | Controlled gate-pull current for the P-switch soft ramp |
| ldo_en | output | 1 | Internal 3.3V standby regulator active |
| pwr_level | output | 2 | 00 S0, 01 S3, 10 S4/S5, 11 not yet powered |

## Verification
The properties assume that sby_por_ok, rail12_good and ss_tick are already synchronous to clk and that ss_tick is at most one cycle wide. Only the two sleep-request pins are treated as asynchronous. The bench therefore changes every input on the falling edge and drives each tick as a single-cycle pulse. It holds every request level for at least one full cycle, so each level reaches the decoder through the synchronizer. The S3-entry property also assumes that ENTRY_DELAY_CYCLES is at least two, which the small bench configuration respects.

// File: rtl/sleep_seq_pkg.sv
`timescale 1ns/1ps
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    REQ_S0  = 2'd0,
    REQ_S3  = 2'd1,
    REQ_S45 = 2'd2
  } sleep_req_e;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_BOOT = 3'd1,
    ST_S3   = 3'd2,
    ST_S45  = 3'd3,
    ST_WAKE = 3'd4,
    ST_S0   = 3'd5
  } seq_state_e;

  localparam logic [1:0] LVL_S0   = 2'b00;
  localparam logic [1:0] LVL_S3   = 2'b01;
  localparam logic [1:0] LVL_S45  = 2'b10;
  localparam logic [1:0] LVL_DOWN = 2'b11;

  typedef struct packed {
    logic       gate_pull;
    logic       psw_on;
    logic       psw_ramp;
    logic       ldo_en;
    logic [1:0] level;
  } rail_cmd_t;

  localparam rail_cmd_t CMD_OFF = '{gate_pull: 1'b1, psw_on: 1'b0,
                                    psw_ramp: 1'b0, ldo_en: 1'b0,
                                    level: LVL_DOWN};

  // S4/S5 has priority over S3; both high requests the active state.
  function automatic sleep_req_e decode_req(input logic s3_n, input logic s5_n);
    if (!s5_n)      return REQ_S45;
    else if (!s3_n) return REQ_S3;
    else            return REQ_S0;
  endfunction

endpackage

// File: rtl/sleep_seq_sync.sv
`timescale 1ns/1ps
module sleep_seq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sleep_seq_entry_timer.sv
`timescale 1ns/1ps
// Counts consecutive cycles of a held request; done on the DELAY_CYCLES-th one.
module sleep_seq_entry_timer #(
  parameter int DELAY_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic done
);
  localparam int CW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = arm && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (arm && !done) cnt_q <= cnt_q + 1'b1;
    else                  cnt_q <= '0;
  end
endmodule

// File: rtl/sleep_seq_wake_qual.sv
`timescale 1ns/1ps
// Counts soft-start ticks while the 12V rail stays good; any drop clears it.
module sleep_seq_wake_qual #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rail_good,
  input  logic tick,
  output logic done
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done = enable && rail_good && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || !rail_good) cnt_q <= '0;
    else if (tick && !done)           cnt_q <= cnt_q + 1'b1;
    else if (done)                    cnt_q <= '0;
  end
endmodule

// File: rtl/sleep_rail_sequencer.sv
`timescale 1ns/1ps
module sleep_rail_sequencer
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES        = 2,
  parameter int ENTRY_DELAY_CYCLES = 12000,
  parameter int WAKE_TICKS         = 3,
  parameter bit KEEP_5V_IN_S45     = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sby_por_ok,
  input  logic       slp3_n,
  input  logic       slp5_n,
  input  logic       rail12_good,
  input  logic       ss_tick,
  output logic       main_gate_pull,
  output logic       psw_on,
  output logic       psw_ramp,
  output logic       ldo_en,
  output logic [1:0] pwr_level
);

  // Request synchronizer and decode
  logic [1:0] slp_sync;
  sleep_req_e req;

  sleep_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({slp5_n, slp3_n}),
    .q   (slp_sync)
  );

  assign req = decode_req(slp_sync[0], slp_sync[1]);

  // Sequencer state
  seq_state_e state_q, state_d;
  logic       origin_s3_q, origin_s3_d;
  logic       entry_done, wake_done;

  sleep_seq_entry_timer #(.DELAY_CYCLES(ENTRY_DELAY_CYCLES)) u_entry (
    .clk  (clk),
    .rst  (rst),
    .arm  ((state_q == ST_S0) && (req == REQ_S3)),
    .done (entry_done)
  );

  sleep_seq_wake_qual #(.TICKS(WAKE_TICKS)) u_wake (
    .clk       (clk),
    .rst       (rst),
    .enable    (state_q == ST_WAKE),
    .rail_good (rail12_good),
    .tick      (ss_tick),
    .done      (wake_done)
  );

  always_comb begin
    state_d     = state_q;
    origin_s3_d = origin_s3_q;
    if (!sby_por_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_BOOT;
        ST_BOOT: if (ss_tick) state_d = (req == REQ_S3) ? ST_S3 : ST_S45;
        ST_S3: begin
          if (req == REQ_S45) state_d = ST_S45;
          else if (req == REQ_S0) begin
            state_d     = ST_WAKE;
            origin_s3_d = 1'b1;
          end
        end
        ST_S45: begin
          // an S3 request here is illegal and leaves the state alone
          if (req == REQ_S0) begin
            state_d     = ST_WAKE;
            origin_s3_d = 1'b0;
          end
        end
        ST_WAKE: begin
          if (req == REQ_S45)     state_d = ST_S45;
          else if (req == REQ_S3) state_d = origin_s3_q ? ST_S3 : ST_S45;
          else if (wake_done)     state_d = ST_S0;
        end
        ST_S0: begin
          if (req == REQ_S45)  state_d = ST_S45;
          else if (entry_done) state_d = ST_S3;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  // Rail commands decoded from the next state, then registered
  rail_cmd_t cmd_q, cmd_d;
  logic      boot_needs_5v;

  assign boot_needs_5v = (req == REQ_S3) || KEEP_5V_IN_S45;

  always_comb begin
    cmd_d = CMD_OFF;
    unique case (state_d)
      ST_OFF:  cmd_d = CMD_OFF;
      ST_BOOT: begin
        cmd_d.ldo_en   = 1'b1;
        cmd_d.psw_ramp = boot_needs_5v;
      end
      ST_S3: begin
        cmd_d.ldo_en = 1'b1;
        cmd_d.psw_on = 1'b1;
        cmd_d.level  = LVL_S3;
      end
      ST_S45: begin
        cmd_d.ldo_en = 1'b1;
        cmd_d.psw_on = KEEP_5V_IN_S45;
        cmd_d.level  = LVL_S45;
      end
      ST_WAKE: begin
        cmd_d.ldo_en = 1'b1;
        cmd_d.psw_on = origin_s3_d ? 1'b1 : KEEP_5V_IN_S45;
        cmd_d.level  = origin_s3_d ? LVL_S3 : LVL_S45;
      end
      ST_S0: begin
        cmd_d.gate_pull = 1'b0;
        cmd_d.level     = LVL_S0;
      end
      default: cmd_d = CMD_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      origin_s3_q <= 1'b0;
      cmd_q       <= CMD_OFF;
    end else begin
      state_q     <= state_d;
      origin_s3_q <= origin_s3_d;
      cmd_q       <= cmd_d;
    end
  end

  assign main_gate_pull = cmd_q.gate_pull;
  assign psw_on         = cmd_q.psw_on;
  assign psw_ramp       = cmd_q.psw_ramp;
  assign ldo_en         = cmd_q.ldo_en;
  assign pwr_level      = cmd_q.level;

endmodule

// File: rtl/sleep_rail_sequencer_chk.sv
`timescale 1ns/1ps
module sleep_rail_sequencer_chk #(
  parameter int ENTRY_DELAY_CYCLES = 12000
) (
  input logic       clk,
  input logic       rst,
  input logic       sby_por_ok,
  input logic       rail12_good,
  input logic       main_gate_pull,
  input logic       psw_on,
  input logic       psw_ramp,
  input logic       ldo_en,
  input logic [1:0] pwr_level
);
  // cycles spent in S0, saturating at the entry delay
  localparam int AW = $clog2(ENTRY_DELAY_CYCLES + 2);
  logic [AW-1:0] s0_age;

  always_ff @(posedge clk) begin
    if (rst || pwr_level != 2'b00)                s0_age <= '0;
    else if (int'(s0_age) < ENTRY_DELAY_CYCLES)   s0_age <= s0_age + 1'b1;
  end

  a_r2_off_without_por: assert property (@(posedge clk) disable iff (rst)
    !sby_por_ok |=> (main_gate_pull && !psw_on && !psw_ramp && !ldo_en && pwr_level == 2'b11));

  a_r3_ramp_only_in_boot: assert property (@(posedge clk) disable iff (rst)
    psw_ramp |-> (ldo_en && !psw_on && pwr_level == 2'b11));

  a_r6_no_s45_to_s3: assert property (@(posedge clk) disable iff (rst)
    (pwr_level == 2'b10) |=> (pwr_level != 2'b01));

  a_r8_s3_entry_delay: assert property (@(posedge clk) disable iff (rst)
    (pwr_level == 2'b00 && int'(s0_age) < ENTRY_DELAY_CYCLES - 1) |=> (pwr_level != 2'b01));

  a_r9_wake_needs_12v: assert property (@(posedge clk) disable iff (rst)
    (main_gate_pull && !rail12_good) |=> main_gate_pull);

  a_r10_rails_switch_together: assert property (@(posedge clk) disable iff (rst)
    $fell(main_gate_pull) |-> (!psw_on && !ldo_en && pwr_level == 2'b00 && $past(ldo_en)));

  a_r12_no_cross_feed: assert property (@(posedge clk) disable iff (rst)
    !(!main_gate_pull && psw_on));

endmodule

bind sleep_rail_sequencer sleep_rail_sequencer_chk #(
  .ENTRY_DELAY_CYCLES(ENTRY_DELAY_CYCLES)
) u_chk (.*);

// File: tb/sleep_rail_sequencer_test.sv
`timescale 1ns/1ps
module sleep_rail_sequencer_test;
  localparam int DLY   = 16;
  localparam int TICKS = 3;
  localparam bit KEEP  = 1'b0;

  logic clk = 1'b0;
  logic rst, sby_por_ok, slp3_n, slp5_n, rail12_good, ss_tick;
  logic main_gate_pull, psw_on, psw_ramp, ldo_en;
  logic [1:0] pwr_level;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  sleep_rail_sequencer #(
    .SYNC_STAGES(2), .ENTRY_DELAY_CYCLES(DLY),
    .WAKE_TICKS(TICKS), .KEEP_5V_IN_S45(KEEP)
  ) uut (
    .clk(clk), .rst(rst), .sby_por_ok(sby_por_ok), .slp3_n(slp3_n),
    .slp5_n(slp5_n), .rail12_good(rail12_good), .ss_tick(ss_tick),
    .main_gate_pull(main_gate_pull), .psw_on(psw_on), .psw_ramp(psw_ramp),
    .ldo_en(ldo_en), .pwr_level(pwr_level)
  );

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic a3n, input logic a5n);
    slp3_n = a3n;
    slp5_n = a5n;
  endtask

  task automatic pulse_tick;
    ss_tick = 1'b1;
    @(negedge clk);
    ss_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] lv, input logic g,
                     input logic p, input logic r, input logic l);
    logic [5:0] got, exp;
    got = {pwr_level, main_gate_pull, psw_on, psw_ramp, ldo_en};
    exp = {lv, g, p, r, l};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {level,gate,psw,ramp,ldo} actual %b expected %b", tag, got, exp);
    end
    checks++;
    if (!main_gate_pull && psw_on) begin
      errors++;
      $display("FAIL R12 during %s: gate=%b psw=%b expected no cross feed",
               tag, main_gate_pull, psw_on);
    end
  endtask

  task automatic chk_off(input string tag);  chk(tag, 2'b11, 1, 0, 0, 0); endtask
  task automatic chk_boot(input string tag, input logic ramp); chk(tag, 2'b11, 1, 0, ramp, 1); endtask
  task automatic chk_s3(input string tag);   chk(tag, 2'b01, 1, 1, 0, 1); endtask
  task automatic chk_s45(input string tag);  chk(tag, 2'b10, 1, KEEP, 0, 1); endtask
  task automatic chk_s0(input string tag);   chk(tag, 2'b00, 0, 0, 0, 0); endtask

  task automatic wake_up;
    drive(1, 1);
    rail12_good = 1'b1;
    cyc(3);
    repeat (TICKS) pulse_tick;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    finish_run();
  end

  initial begin
    rst = 1; sby_por_ok = 0; slp3_n = 0; slp5_n = 0; rail12_good = 0; ss_tick = 0;
    cyc(3);
    chk_off("R2 reset");
    rst = 0;
    cyc(3);
    chk_off("R2 standby not ready");

    // boot towards S3 with the soft ramp current
    drive(0, 1);
    cyc(4);
    sby_por_ok = 1;
    cyc(1);
    chk_boot("R3 boot ramp", 1'b1);
    cyc(3);
    chk_boot("R3 boot held until tick", 1'b1);
    pulse_tick;
    chk_s3("R3 R4 boot exit to S3");

    // wake without the 12V rail
    drive(1, 1);
    rail12_good = 0;
    cyc(3);
    repeat (4) pulse_tick;
    chk_s3("R9 no 12V no wake");
    rail12_good = 1;
    pulse_tick; pulse_tick;
    chk_s3("R9 two intervals not enough");
    rail12_good = 0;
    cyc(1);
    rail12_good = 1;
    pulse_tick; pulse_tick;
    chk_s3("R9 count restarts after 12V drop");
    pulse_tick;
    chk_s0("R10 all rails switched");

    // S0 to S3 qualification delay
    drive(0, 1);
    cyc(DLY + 1);
    chk_s0("R8 held before delay");
    cyc(1);
    chk_s3("R8 S3 at delay");

    // delay restart
    wake_up;
    chk_s0("R9 R10 wake from S3");
    drive(0, 1);
    cyc(10);
    drive(1, 1);
    cyc(1);
    drive(0, 1);
    cyc(DLY + 1);
    chk_s0("R8 restart holds S0");
    cyc(1);
    chk_s3("R8 restart expires");

    // S0 to S4/S5 at once
    wake_up;
    drive(1, 0);
    cyc(2);
    chk_s0("R7 before sync latency");
    cyc(1);
    chk_s45("R5 R7 immediate S4/S5");

    // illegal S4/S5 to S3
    drive(0, 1);
    cyc(30);
    chk_s45("R6 S3 request ignored");

    // wake aborted to origin, then wake count restarts
    drive(1, 1);
    cyc(3);
    pulse_tick;
    drive(0, 1);
    cyc(3);
    chk_s45("R11 abort returns to S4/S5");
    drive(1, 1);
    cyc(3);
    pulse_tick; pulse_tick;
    chk_s45("R11 wake count started again");
    pulse_tick;
    chk_s0("R11 R10 wake completes");

    // sweep of every pin code from S0
    for (int code = 0; code < 4; code++) begin
      logic a3n, a5n;
      a3n = code[0];
      a5n = code[1];
      drive(a3n, a5n);
      cyc(3 + DLY);
      if (!a5n)      chk_s45($sformatf("R1 code %0d -> S4/S5", code));
      else if (!a3n) chk_s3($sformatf("R1 code %0d -> S3", code));
      else           chk_s0($sformatf("R1 code %0d -> S0", code));
      if (!(a3n && a5n)) wake_up;
      chk_s0($sformatf("R1 back to S0 after code %0d", code));
    end

    // loss of standby qualifier, then boot toward S4/S5
    sby_por_ok = 0;
    cyc(1);
    chk_off("R2 qualifier lost");
    drive(0, 0);
    cyc(3);
    sby_por_ok = 1;
    cyc(1);
    chk_boot("R3 boot for S4/S5", KEEP);
    pulse_tick;
    chk_s45("R3 R5 boot exit to S4/S5");

    finish_run();
  end
endmodule